// File: doc/BRIEF.md
# Configuration Port Register Readback Sequencer

This block reads a single 32-bit register (device status or device identification) through a 32-bit internal configuration access port. The port has an active-low chip select, a direction select and separate 32-bit write and read buses. A one-cycle start request latches the register choice. The block then writes a fixed stream of words: bus-width detection, synchronisation, a read packet header and padding no-ops. It turns the port around, takes one returned word after a configurable latency, turns the port back and closes the session with a desynchronise command.

Both data buses carry words with the bit order reversed inside each byte and the byte order kept. The block applies this reversal itself, so the host-side result and the internal word constants read naturally. Every word is presented for one cycle with chip select high and then held for one cycle with chip select low. The direction select only moves while chip select is high on both sides of the edge.

Top module: `cfgrb_top`

## Requirements
- R1: After the asynchronous active-low reset, chip select is high, direction is write (`cfg_rdwrn_o`=0), the write bus is all ones, busy and done are low and the result is zero.
- R2: A session opens by writing, in this order, 0xFFFFFFFF, 0x000000BB, 0x11220044, 0xFFFFFFFF, 0xAA995566, 0x20000000 (values before bit reversal).
- R3: Next come the read header and two 0x20000000 no-ops. The header is {3'b001, 2'b01 (read), 9'b0, address[4:0], 2'b0, count[10:0]=1}. With `reg_sel_i`=0 it reads address 0x07 (0x2800E001), and with 1 it reads address 0x0C (0x28018001).
- R4: Each data bus word has its bits reversed inside every byte, with byte positions unchanged. For example, 0xAA995566 appears on the write bus as 0x5599AA66.
- R5: Each written word is driven for one cycle with chip select high. The same value is then held for one cycle with chip select low, and chip select returns high between words.
- R6: The direction select is 1 for read and 0 for write. It changes only at an edge where chip select is high in the cycles before and after it. Chip select is low in read mode for exactly RD_LAT consecutive cycles per session.
- R7: The result is the bit-reversed value of `cfg_rdata_i` sampled at the RD_LAT-th rising edge of the read-mode chip select window.
- R8: After the read, the session writes 0x30008001 (type-1 write of one word to command address 0x04), 0x0000000D (desynchronise), then two 0x20000000 no-ops. That makes 13 written words per session.
- R9: Busy rises in the cycle after the accepted start. Done is high for exactly one cycle, the cycle right after the chip-select-low cycle of the final no-op, and busy falls in that same cycle.
- R10: A start request while busy is ignored, and the register selector is sampled only when a start is accepted. A session never writes more than 13 words or signals done more than once.
- R11: The result changes only at the capture edge and is otherwise held, including while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| reg_sel_i | input | 1 | 0 reads status (0x07), 1 reads identification (0x0C) |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle end-of-session pulse |
| result_o | output | 32 | Captured register value, natural bit order |
| cfg_csn_o | output | 1 | Port chip select, active low |
| cfg_rdwrn_o | output | 1 | Port direction, 1 read, 0 write |
| cfg_wdata_o | output | 32 | Port write bus, bit-reversed per byte |
| cfg_rdata_i | input | 32 | Port read bus, bit-reversed per byte |

## Verification
The bench builds the block with RD_LAT set to 3 instead of the default 2. This makes the latency counter pass through intermediate values before capture. The port model in the bench presents a different read value on every cycle of the read window, so a capture taken one edge early or late gives a wrong result. Sessions alternate between the two register choices, and random start pulses and selector changes are applied during busy. One session is cut short by an asynchronous reset.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned N_OPEN   = 9;   // words written before the read
    localparam int unsigned N_TOTAL  = 13;  // words written per session
    localparam int unsigned IDX_W    = $clog2(N_TOTAL);

    localparam logic [WORD_W-1:0] W_DUMMY   = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] W_WSYNC   = 32'h0000_00BB;
    localparam logic [WORD_W-1:0] W_WDETECT = 32'h1122_0044;
    localparam logic [WORD_W-1:0] W_SYNC    = 32'hAA99_5566;
    localparam logic [WORD_W-1:0] W_NOOP    = 32'h2000_0000;
    localparam logic [WORD_W-1:0] W_DESYNC  = 32'h0000_000D;

    localparam logic [1:0] OP_READ  = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam logic [4:0] ADDR_CMD = 5'h04;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DRIVE,
        ST_TO_RD,
        ST_RD_PREP,
        ST_RD_ON,
        ST_TO_WR
    } seq_state_e;

    function automatic logic [WORD_W-1:0] type1_hdr(
        input logic [1:0]  op,
        input logic [4:0]  addr,
        input logic [10:0] count
    );
        return {3'b001, op, 9'd0, addr, 2'd0, count};
    endfunction

    function automatic logic [WORD_W-1:0] word_at(
        input logic [IDX_W-1:0] idx,
        input logic             sel,
        input logic [4:0]       stat_addr,
        input logic [4:0]       id_addr
    );
        logic [WORD_W-1:0] w;
        case (idx)
            4'd0, 4'd3: w = W_DUMMY;
            4'd1:       w = W_WSYNC;
            4'd2:       w = W_WDETECT;
            4'd4:       w = W_SYNC;
            4'd6:       w = type1_hdr(OP_READ, sel ? id_addr : stat_addr, 11'd1);
            4'd9:       w = type1_hdr(OP_WRITE, ADDR_CMD, 11'd1);
            4'd10:      w = W_DESYNC;
            default:    w = W_NOOP;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cfgrb_bitswap.sv
module cfgrb_bitswap #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned NBYTES = W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[b*8 + i] = din[b*8 + 7 - i];
        end
    end

    initial begin
        assert (W % 8 == 0) else $error("bus width must be a whole number of bytes");
    end
endmodule

// File: rtl/cfgrb_seq.sv
module cfgrb_seq
    import cfgrb_pkg::*;
#(
    parameter int unsigned RD_LAT    = 2,
    parameter logic [4:0]  STAT_ADDR = 5'h07,
    parameter logic [4:0]  ID_ADDR   = 5'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sel_i,
    input  logic [WORD_W-1:0] rword_i,
    output logic              csn_o,
    output logic              rdwrn_o,
    output logic [WORD_W-1:0] wword_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o
);
    localparam int unsigned CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT - 1);
    localparam logic [IDX_W-1:0] IDX_OPEN_LAST = IDX_W'(N_OPEN - 1);
    localparam logic [IDX_W-1:0] IDX_CLOSE_FIRST = IDX_W'(N_OPEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_TOTAL - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic              sel;
        logic              csn;
        logic              rdwrn;
        logic [WORD_W-1:0] wword;
        logic              busy;
        logic              done;
        logic [WORD_W-1:0] result;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    nxt_d.st    = ST_SETUP;
                    nxt_d.busy  = 1'b1;
                    nxt_d.sel   = sel_i;
                    nxt_d.idx   = '0;
                    nxt_d.csn   = 1'b1;
                    nxt_d.rdwrn = 1'b0;
                    nxt_d.wword = word_at('0, sel_i, STAT_ADDR, ID_ADDR);
                end
            end
            ST_SETUP: begin
                nxt_d.st  = ST_DRIVE;
                nxt_d.csn = 1'b0;
            end
            ST_DRIVE: begin
                nxt_d.csn = 1'b1;
                if (cur_q.idx == IDX_LAST) begin
                    nxt_d.st    = ST_IDLE;
                    nxt_d.busy  = 1'b0;
                    nxt_d.done  = 1'b1;
                    nxt_d.wword = '1;
                end else if (cur_q.idx == IDX_OPEN_LAST) begin
                    nxt_d.st    = ST_TO_RD;
                    nxt_d.wword = '1;
                end else begin
                    nxt_d.st    = ST_SETUP;
                    nxt_d.idx   = cur_q.idx + IDX_W'(1);
                    nxt_d.wword = word_at(cur_q.idx + IDX_W'(1), cur_q.sel,
                                          STAT_ADDR, ID_ADDR);
                end
            end
            ST_TO_RD: begin
                nxt_d.st    = ST_RD_PREP;
                nxt_d.rdwrn = 1'b1;
            end
            ST_RD_PREP: begin
                nxt_d.st  = ST_RD_ON;
                nxt_d.csn = 1'b0;
                nxt_d.cnt = '0;
            end
            ST_RD_ON: begin
                if (cur_q.cnt == CNT_LAST) begin
                    nxt_d.result = rword_i;
                    nxt_d.csn    = 1'b1;
                    nxt_d.st     = ST_TO_WR;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_TO_WR: begin
                nxt_d.st    = ST_SETUP;
                nxt_d.rdwrn = 1'b0;
                nxt_d.idx   = IDX_CLOSE_FIRST;
                nxt_d.wword = word_at(IDX_CLOSE_FIRST, cur_q.sel, STAT_ADDR, ID_ADDR);
            end
            default: begin
                nxt_d = cur_q;
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st     <= ST_IDLE;
            cur_q.idx    <= '0;
            cur_q.cnt    <= '0;
            cur_q.sel    <= 1'b0;
            cur_q.csn    <= 1'b1;
            cur_q.rdwrn  <= 1'b0;
            cur_q.wword  <= '1;
            cur_q.busy   <= 1'b0;
            cur_q.done   <= 1'b0;
            cur_q.result <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign csn_o    = cur_q.csn;
    assign rdwrn_o  = cur_q.rdwrn;
    assign wword_o  = cur_q.wword;
    assign busy_o   = cur_q.busy;
    assign done_o   = cur_q.done;
    assign result_o = cur_q.result;

    // direction moves only with chip select high on both sides of the edge
    assert_dir_change_csn_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.rdwrn) |-> (cur_q.csn && $past(cur_q.csn)));

    assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.done |=> !cur_q.done);

    assert_idle_port_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.busy |-> (cur_q.csn && !cur_q.rdwrn));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st != ST_RD_ON) |=> $stable(cur_q.result));

    assert_busy_kept_mid_session_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && cur_q.st != ST_DRIVE) |=> cur_q.busy);

    assert_word_held_while_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.csn && !cur_q.rdwrn) |-> ($past(cur_q.csn) && $stable(cur_q.wword)));

endmodule

// File: rtl/cfgrb_top.sv
module cfgrb_top
    import cfgrb_pkg::*;
#(
    parameter int unsigned RD_LAT    = 2,
    parameter logic [4:0]  STAT_ADDR = 5'h07,
    parameter logic [4:0]  ID_ADDR   = 5'h0C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        reg_sel_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [31:0] result_o,
    output logic        cfg_csn_o,
    output logic        cfg_rdwrn_o,
    output logic [31:0] cfg_wdata_o,
    input  logic [31:0] cfg_rdata_i
);
    logic [WORD_W-1:0] wword_nat;
    logic [WORD_W-1:0] rword_nat;

    cfgrb_bitswap #(.W(WORD_W)) i_swap_rd (
        .din  (cfg_rdata_i),
        .dout (rword_nat)
    );

    cfgrb_seq #(
        .RD_LAT    (RD_LAT),
        .STAT_ADDR (STAT_ADDR),
        .ID_ADDR   (ID_ADDR)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sel_i    (reg_sel_i),
        .rword_i  (rword_nat),
        .csn_o    (cfg_csn_o),
        .rdwrn_o  (cfg_rdwrn_o),
        .wword_o  (wword_nat),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    cfgrb_bitswap #(.W(WORD_W)) i_swap_wr (
        .din  (wword_nat),
        .dout (cfg_wdata_o)
    );

    initial begin
        assert (RD_LAT >= 1) else $error("read latency must be at least one cycle");
    end
endmodule

// File: tb/test_cfgrb_top.sv
module test_cfgrb_top;
    localparam int RD_LAT = 3;
    localparam logic [31:0] MIX = 32'h9E37_79B9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] rdata = '1;
    logic        busy, done, csn, rdwrn;
    logic [31:0] result, wdata;

    always #10 clk = ~clk;

    cfgrb_top #(.RD_LAT(RD_LAT)) i_cfgrb_top (
        .clk(clk), .rst_n(rst_n), .start_i(start), .reg_sel_i(sel),
        .busy_o(busy), .done_o(done), .result_o(result),
        .cfg_csn_o(csn), .cfg_rdwrn_o(rdwrn), .cfg_wdata_o(wdata),
        .cfg_rdata_i(rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rev8(input logic [31:0] v);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                r[b*8 + i] = v[b*8 + 7 - i];
        return r;
    endfunction

    function automatic logic [31:0] exp_word(input int i, input bit s);
        case (i)
            0, 3:  return 32'hFFFF_FFFF;
            1:     return 32'h0000_00BB;
            2:     return 32'h1122_0044;
            4:     return 32'hAA99_5566;
            6:     return s ? 32'h2801_8001 : 32'h2800_E001;
            9:     return 32'h3000_8001;
            10:    return 32'h0000_000D;
            default: return 32'h2000_0000;
        endcase
    endfunction

    // port model and monitor
    logic [31:0] wlog [16];
    logic [31:0] sync_raw;
    int wcnt, rd_cycles, rd_k, csn_viol, dir_viol, done_cnt;
    int cyc, last_wr_cyc, done_cyc;
    logic prev_csn = 1'b1, prev_rdwrn = 1'b0;
    logic [31:0] prev_wdata = '1;
    logic [31:0] base = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!csn && !rdwrn) begin
                if (wcnt < 16) wlog[wcnt] = rev8(wdata);
                if (wcnt == 4) sync_raw = wdata;
                wcnt++;
                last_wr_cyc = cyc;
                if (!(prev_csn && prev_wdata == wdata)) csn_viol++;
            end
            if (rdwrn !== prev_rdwrn && !(csn && prev_csn)) dir_viol++;
            if (!csn && rdwrn) begin
                rdata = rev8(base ^ (32'(rd_k) * MIX));
                rd_k++;
                rd_cycles++;
            end else begin
                rd_k = 0;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
        prev_csn   = csn;
        prev_rdwrn = rdwrn;
        prev_wdata = wdata;
    end

    task automatic clear_mon();
        wcnt = 0; rd_cycles = 0; rd_k = 0; csn_viol = 0; dir_viol = 0;
        done_cnt = 0; last_wr_cyc = -10; done_cyc = -20;
        for (int i = 0; i < 16; i++) wlog[i] = 'x;
    endtask

    task automatic check_idle(input string tag);
        chk(csn === 1'b1,   {tag, " R1 csn"},    {31'd0, csn},   32'd1);
        chk(rdwrn === 1'b0, {tag, " R1 rdwrn"},  {31'd0, rdwrn}, 32'd0);
        chk(wdata === '1,   {tag, " R1 wdata"},  wdata,          32'hFFFF_FFFF);
        chk(busy === 1'b0 && done === 1'b0, {tag, " R1 busy/done"},
            {30'd0, busy, done}, 32'd0);
    endtask

    task automatic session(input bit s, input bit noisy);
        logic [31:0] exp_res;
        int wait_cnt;
        @(negedge clk); #2;
        clear_mon();
        base = $urandom;
        start = 1'b1; sel = s;
        @(negedge clk); #2;
        start = 1'b0; sel = ~s;
        chk(busy === 1'b1, "R9 busy after start", {31'd0, busy}, 32'd1);
        wait_cnt = 0;
        while (done_cnt == 0 && wait_cnt < 500) begin
            @(negedge clk); #2;
            if (done_cnt != 0) break;
            start = noisy && ($urandom % 4 == 0);
            sel = 1'($urandom);
            wait_cnt++;
        end
        start = 1'b0;
        chk(done_cnt == 1, "R9 done seen", 32'(done_cnt), 32'd1);
        chk(done_cyc == last_wr_cyc + 1, "R9 done after final word",
            32'(done_cyc), 32'(last_wr_cyc + 1));
        chk(busy === 1'b0, "R9 busy falls with done", {31'd0, busy}, 32'd0);
        @(negedge clk); #2;
        chk(done === 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        #2;
        chk(wcnt == 13 && done_cnt == 1, "R10 no restart while busy",
            32'(wcnt), 32'd13);
        for (int i = 0; i < 6; i++)
            chk(wlog[i] === exp_word(i, s), $sformatf("R2 word %0d", i),
                wlog[i], exp_word(i, s));
        for (int i = 6; i < 9; i++)
            chk(wlog[i] === exp_word(i, s), $sformatf("R3 word %0d sel=%0d", i, s),
                wlog[i], exp_word(i, s));
        for (int i = 9; i < 13; i++)
            chk(wlog[i] === exp_word(i, s), $sformatf("R8 word %0d", i),
                wlog[i], exp_word(i, s));
        chk(sync_raw === 32'h5599_AA66, "R4 sync word on pins", sync_raw, 32'h5599_AA66);
        exp_res = base ^ (32'(RD_LAT - 1) * MIX);
        chk(result === exp_res, "R7 captured word", result, exp_res);
        chk(csn_viol == 0, "R5 word framing", 32'(csn_viol), 32'd0);
        chk(dir_viol == 0, "R6 direction change", 32'(dir_viol), 32'd0);
        chk(rd_cycles == RD_LAT, "R6 read window length", 32'(rd_cycles), 32'(RD_LAT));
        // R11: read bus noise while idle must not move the result
        for (int k = 0; k < 5; k++) begin
            rdata = $urandom;
            @(negedge clk); #2;
        end
        chk(result === exp_res, "R11 result held", result, exp_res);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_mon();
        repeat (3) @(negedge clk);
        #2;
        check_idle("reset");
        chk(result === '0, "R1 result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check_idle("after release");

        session(1'b0, 1'b0);
        session(1'b1, 1'b0);
        session(1'b0, 1'b1);
        session(1'b1, 1'b1);

        // reset in the middle of a session
        @(negedge clk); #2;
        start = 1'b1; sel = 1'b0;
        @(negedge clk); #2;
        start = 1'b0;
        repeat (15) @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        check_idle("mid-session reset");
        @(negedge clk); #2;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check_idle("after mid reset");

        for (int n = 0; n < 16; n++)
            session(1'($urandom), 1'($urandom));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule